// File: doc/BRIEF.md
# Byte-Lane Bus Access Splitter

This block sits between a processor's load/store port and an external data bus built from four byte-wide memory banks. It accepts one access at a time (a byte, a 16-bit half or a 32-bit word at any byte address) and runs as many bus cycles as the operand needs. Each cycle carries an aligned address and active-low byte-lane enables. Write bytes are steered onto the lanes that match their addresses. Read bytes are gathered back into a right-justified result.

An operand that fits inside one aligned bus word takes one cycle. An operand that crosses a boundary is split, and the lower address goes first. A narrow-bus input selects a mode in which only the low two lanes carry data. The block then walks the operand one aligned halfword at a time. Every bus cycle is held until the ready input is seen high, and the result is delivered once, after the last cycle completes.

Top module: `bus_lane_splitter`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, bus_rd and bus_wr are 0 and bus_be_n is 4'b1111.
- R2: In wide mode (bus_narrow=0), an operand whose bytes all lie in one 4-byte-aligned word completes in exactly one bus cycle.
- R3: In wide mode, an operand that crosses a 4-byte boundary takes two bus cycles. The first has the lower aligned address and the second has that address plus 4. Every wide-mode bus_addr has bits [1:0] = 0.
- R4: bus_be_n[l] is 0 exactly when the byte at bus_addr+l belongs to the operand. In every active cycle at least one lane is enabled.
- R5: Writes are little-endian. Operand byte i (bits 8i+7:8i of req_wdata) is stored at byte address req_addr+i, and no other byte is changed.
- R6: Read results are little-endian and right-justified. Byte i of rsp_rdata comes from address req_addr+i, and bits above the operand size are 0.
- R7: The req_size code 0 selects 1 byte, 1 selects 2 bytes, 2 selects 4 bytes, and 3 is treated as 4 bytes.
- R8: With bus_narrow=1 at acceptance, only lanes 0 and 1 are used (bus_be_n[3:2]=2'b11), bus_addr is halfword-aligned, and one cycle runs for each aligned halfword the operand touches, lowest first.
- R9: While a bus cycle is active and bus_ready is 0, bus_addr, bus_be_n and the read/write direction stay unchanged.
- R10: req_ready is 0 while an access is in progress. rsp_valid pulses for one cycle, on the cycle after the final bus cycle is accepted with bus_ready=1.
- R11: bus_rd and bus_wr are never both 1. bus_wr is asserted for writes and bus_rd for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when req_ready is 1 |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Operand size code (0 byte, 1 half, 2/3 word) |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | output | 1 | One-cycle pulse: access finished |
| rsp_rdata | output | 32 | Load result, right-justified, zero-extended |
| bus_narrow | input | 1 | 1 = bus uses only the low 16 data lines |
| bus_addr | output | ADDR_W | Aligned address of the current bus cycle |
| bus_be_n | output | 4 | Active-low byte-lane enables |
| bus_rd | output | 1 | Read bus cycle active |
| bus_wr | output | 1 | Write bus cycle active |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data from the lanes |
| bus_ready | input | 1 | Current bus cycle completes at this edge |

## Verification
The assertions assume that bus_ready only matters while a bus cycle is active. They also assume that bus_narrow and the request fields are sampled only at acceptance, so changes on them at other times are harmless. The bench's memory model follows these rules: it raises ready only during active cycles, it inserts a configurable number of wait cycles before each transfer, and it drives the upper lanes with junk in narrow mode. Requests are presented only while req_ready is 1. Addresses stay inside a small modelled memory that does not wrap.

// File: rtl/lane_pkg.sv
package lane_pkg;
  parameter int unsigned LANES = 4;
  localparam int unsigned OW = $clog2(LANES);
  localparam int unsigned CW = OW + 1;
  localparam int unsigned DW = 8 * LANES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } state_e;

  // size code to operand byte count; code 3 behaves as a full word
  function automatic logic [CW-1:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = CW'(1);
      2'd1:    size_bytes = CW'(2);
      default: size_bytes = CW'(4);
    endcase
  endfunction
endpackage

// File: rtl/lane_window.sv
// Picks the lanes used by the current bus cycle: first lane, byte count, enables.
module lane_window
  import lane_pkg::*;
(
  input  logic [OW-1:0]    cur_off,
  input  logic [CW-1:0]    rem,
  input  logic             narrow,
  output logic [OW-1:0]    lane_lo,
  output logic [CW-1:0]    take,
  output logic [LANES-1:0] be_n
);
  logic [CW-1:0] cap;

  always_comb begin
    if (narrow) begin
      lane_lo = {1'b0, cur_off[OW-2:0]};
      cap     = CW'(LANES / 2) - {1'b0, lane_lo};
    end else begin
      lane_lo = cur_off;
      cap     = CW'(LANES) - {1'b0, cur_off};
    end
    take = (rem < cap) ? rem : cap;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be_n[l] = !((CW'(l) >= {1'b0, lane_lo}) &&
                       (CW'(l) <  ({1'b0, lane_lo} + take)));
  end
endmodule

// File: rtl/lane_wsteer.sv
// Places operand bytes onto the lanes that match their byte addresses.
module lane_wsteer
  import lane_pkg::*;
(
  input  logic [DW-1:0] opnd,
  input  logic [CW-1:0] done,
  input  logic [OW-1:0] lane_lo,
  output logic [DW-1:0] lanes
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CW:0] idx;
    always_comb begin
      idx = {1'b0, done} + (CW+1)'(l) - {2'b00, lane_lo};
      if (idx < (CW+1)'(LANES))
        lanes[8*l +: 8] = opnd[8*idx[OW-1:0] +: 8];
      else
        lanes[8*l +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/lane_rmerge.sv
// Collects the lanes of one bus cycle into the right-justified accumulator.
module lane_rmerge
  import lane_pkg::*;
(
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rdata,
  input  logic [CW-1:0] done,
  input  logic [OW-1:0] lane_lo,
  input  logic [CW-1:0] take,
  output logic [DW-1:0] merged
);
  for (genvar p = 0; p < LANES; p++) begin : g_byte
    logic [OW-1:0] src;
    logic          hit;
    always_comb begin
      src = OW'(p) - done[OW-1:0] + lane_lo;
      hit = ((CW+1)'(p) >= {1'b0, done}) &&
            ((CW+1)'(p) <  ({1'b0, done} + {1'b0, take}));
      merged[8*p +: 8] = hit ? rdata[8*src +: 8] : acc[8*p +: 8];
    end
  end
endmodule

// File: rtl/bus_lane_splitter.sv
module bus_lane_splitter
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              bus_narrow,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be_n,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  state_e            state_q, state_d;
  logic              wr_q, wr_d;
  logic              narrow_q, narrow_d;
  logic [CW-1:0]     total_q, total_d;
  logic [CW-1:0]     done_q, done_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [DW-1:0]     wdata_q, wdata_d;
  logic [DW-1:0]     acc_q, acc_d;
  logic              dp_en;

  logic              active;
  logic [CW-1:0]     rem;
  logic [OW-1:0]     lane_lo;
  logic [CW-1:0]     take;
  logic [LANES-1:0]  be_n_w;
  logic [DW-1:0]     steer_w;
  logic [DW-1:0]     merged_w;

  assign active = (state_q == ST_BUS);
  assign rem    = total_q - done_q;

  lane_window u_window (
    .cur_off (cur_q[OW-1:0]),
    .rem     (rem),
    .narrow  (narrow_q),
    .lane_lo (lane_lo),
    .take    (take),
    .be_n    (be_n_w)
  );

  lane_wsteer u_wsteer (
    .opnd    (wdata_q),
    .done    (done_q),
    .lane_lo (lane_lo),
    .lanes   (steer_w)
  );

  lane_rmerge u_rmerge (
    .acc     (acc_q),
    .rdata   (bus_rdata),
    .done    (done_q),
    .lane_lo (lane_lo),
    .take    (take),
    .merged  (merged_w)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    wr_d     = wr_q;
    narrow_d = narrow_q;
    total_d  = total_q;
    done_d   = done_q;
    cur_d    = cur_q;
    wdata_d  = wdata_q;
    acc_d    = acc_q;
    dp_en    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          dp_en    = 1'b1;
          state_d  = ST_BUS;
          wr_d     = req_write;
          narrow_d = bus_narrow;
          total_d  = size_bytes(req_size);
          done_d   = '0;
          cur_d    = req_addr;
          wdata_d  = req_wdata;
          acc_d    = '0;
        end
      end
      ST_BUS: begin
        if (bus_ready) begin
          dp_en  = 1'b1;
          done_d = done_q + take;
          cur_d  = cur_q + ADDR_W'(take);
          if (!wr_q) acc_d = merged_w;
          if ((done_q + take) == total_q) state_d = ST_RESP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  // datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (dp_en) begin
      wr_q     <= wr_d;
      narrow_q <= narrow_d;
      total_q  <= total_d;
      done_q   <= done_d;
      cur_q    <= cur_d;
      wdata_q  <= wdata_d;
      acc_q    <= acc_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = acc_q;
  assign bus_rd    = active && !wr_q;
  assign bus_wr    = active && wr_q;
  assign bus_be_n  = active ? be_n_w : '1;
  assign bus_wdata = bus_wr ? steer_w : '0;
  assign bus_addr  = narrow_q ? {cur_q[ADDR_W-1:OW-1], {(OW-1){1'b0}}}
                              : {cur_q[ADDR_W-1:OW], {OW{1'b0}}};
endmodule

module bus_lane_splitter_chk
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ready,
  input logic              mode_narrow,
  input logic [LANES-1:0]  bus_be_n,
  input logic [ADDR_W-1:0] bus_addr
);
  logic act;
  assign act = bus_rd || bus_wr;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wr) && act));

  p_dir_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

  p_narrow_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode_narrow) |-> (bus_be_n[3:2] == 2'b11 && bus_addr[0] == 1'b0));

  p_wide_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !mode_narrow) |-> (bus_addr[1:0] == 2'b00));

  p_some_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (bus_be_n != 4'hF));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !req_ready);

  p_rsp_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_ready && (bus_rd || bus_wr)));
endmodule

bind bus_lane_splitter bus_lane_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_ready   (bus_ready),
  .mode_narrow (narrow_q),
  .bus_be_n    (bus_be_n),
  .bus_addr    (bus_addr)
);

// File: tb/bus_lane_splitter_bench.sv
`timescale 1ns/1ps
module bus_lane_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_narrow;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;

  always #2 clk = ~clk;

  bus_lane_splitter #(.ADDR_W(32)) u_bus_lane_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_narrow(bus_narrow), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0] mem [64];

  // bus model state
  int          wait_n = 0;
  int          wcnt = 0;
  int          log_n = 0;
  logic [31:0] log_addr [8];
  logic [3:0]  log_be [8];
  logic        log_wr [8];
  int          hold_err = 0;
  int          excl_err = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr;
  logic [3:0]  prev_be;
  logic        cur_narrow = 1'b0;

  always @(negedge clk) begin
    if (bus_rd && bus_wr) excl_err <= excl_err + 1;
    if (bus_rd || bus_wr) begin
      if (prev_wait && (bus_addr !== prev_addr || bus_be_n !== prev_be))
        hold_err <= hold_err + 1;
      prev_addr <= bus_addr;
      prev_be   <= bus_be_n;
      if (wcnt < wait_n) begin
        bus_ready <= 1'b0;
        prev_wait <= 1'b1;
        wcnt      <= wcnt + 1;
        bus_rdata <= 32'hDEAD_BEEF;
      end else begin
        bus_ready <= 1'b1;
        prev_wait <= 1'b0;
        wcnt      <= 0;
        if (log_n < 8) begin
          log_addr[log_n] <= bus_addr;
          log_be[log_n]   <= bus_be_n;
          log_wr[log_n]   <= bus_wr;
        end
        log_n <= log_n + 1;
        for (int l = 0; l < 4; l++) begin
          if (bus_wr && !bus_be_n[l])
            mem[(bus_addr + l) & 32'd63] <= bus_wdata[8*l +: 8];
          if (cur_narrow && l >= 2)
            bus_rdata[8*l +: 8] <= 8'hEE;
          else
            bus_rdata[8*l +: 8] <= mem[(bus_addr + l) & 32'd63];
        end
      end
    end else begin
      bus_ready <= 1'b0;
      prev_wait <= 1'b0;
      wcnt      <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = mem[(a + i) & 63];
    return r;
  endfunction

  task automatic run_acc(input bit wr, input logic [1:0] sz, input int a,
                         input logic [31:0] wd, input bit nar, output logic [31:0] rd);
    int cnt = 0;
    @(negedge clk);
    log_n      = 0;
    cur_narrow = nar;
    req_valid  = 1'b1;
    req_write  = wr;
    req_size   = sz;
    req_addr   = a;
    req_wdata  = wd;
    bus_narrow = nar;
    @(negedge clk);
    req_valid  = 1'b0;
    bus_narrow = ~nar;
    req_wdata  = 32'h0BAD_0BAD;
    chk(req_ready == 1'b0, "R10 busy", {31'b0, req_ready}, 32'h0);
    while (!rsp_valid && cnt < 500) begin
      @(negedge clk);
      cnt++;
    end
    chk(rsp_valid == 1'b1, "R10 response", {31'b0, rsp_valid}, 32'h1);
    rd = rsp_rdata;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 single pulse", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic chk_log(input int i, input logic [31:0] a, input logic [3:0] be,
                         input bit wr, input string req);
    chk(log_addr[i] == a, req, log_addr[i], a);
    chk(log_be[i] == be, req, {28'b0, log_be[i]}, {28'b0, be});
    chk(log_wr[i] == wr, "R11 direction", {31'b0, log_wr[i]}, {31'b0, wr});
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk({bus_rd, bus_wr} == 2'b00, "R1 bus idle", {30'b0, bus_rd, bus_wr}, 32'h0);
    chk(bus_be_n == 4'hF, "R1 enables off", {28'b0, bus_be_n}, 32'hF);
  endtask

  task automatic t_wide_single;
    logic [31:0] r;
    run_acc(1'b0, 2'd0, 5, 32'h0, 1'b0, r);
    chk(log_n == 1, "R2 byte one cycle", log_n, 1);
    chk_log(0, 32'd4, 4'b1101, 1'b0, "R4 byte lane");
    chk(r == exp_read(5, 1), "R6 byte zero-extended", r, exp_read(5, 1));
    run_acc(1'b0, 2'd1, 6, 32'h0, 1'b0, r);
    chk(log_n == 1, "R2 half one cycle", log_n, 1);
    chk_log(0, 32'd4, 4'b0011, 1'b0, "R4 half lanes");
    chk(r == exp_read(6, 2), "R6 half data", r, exp_read(6, 2));
    run_acc(1'b0, 2'd2, 8, 32'h0, 1'b0, r);
    chk(log_n == 1, "R2 word one cycle", log_n, 1);
    chk_log(0, 32'd8, 4'b0000, 1'b0, "R4 word lanes");
    chk(r == exp_read(8, 4), "R6 word data", r, exp_read(8, 4));
    run_acc(1'b0, 2'd3, 16, 32'h0, 1'b0, r);
    chk(log_n == 1, "R7 code 3 cycles", log_n, 1);
    chk_log(0, 32'd16, 4'b0000, 1'b0, "R7 code 3 lanes");
    chk(r == exp_read(16, 4), "R7 code 3 is word", r, exp_read(16, 4));
  endtask

  task automatic t_wide_split;
    logic [31:0] r;
    run_acc(1'b0, 2'd1, 7, 32'h0, 1'b0, r);
    chk(log_n == 2, "R3 half split cycles", log_n, 2);
    chk_log(0, 32'd4, 4'b0111, 1'b0, "R3 half first");
    chk_log(1, 32'd8, 4'b1110, 1'b0, "R3 half second");
    chk(r == exp_read(7, 2), "R6 split half data", r, exp_read(7, 2));
    run_acc(1'b0, 2'd2, 13, 32'h0, 1'b0, r);
    chk(log_n == 2, "R3 word split cycles", log_n, 2);
    chk_log(0, 32'd12, 4'b0001, 1'b0, "R3 word first");
    chk_log(1, 32'd16, 4'b1110, 1'b0, "R3 word second");
    chk(r == exp_read(13, 4), "R6 split word data", r, exp_read(13, 4));
  endtask

  task automatic t_writes;
    logic [31:0] r;
    logic [7:0]  b20, b25, b32, b41;
    b20 = mem[20]; b25 = mem[25];
    run_acc(1'b1, 2'd2, 21, 32'hA1B2_C3D4, 1'b0, r);
    chk(log_n == 2, "R3 write split cycles", log_n, 2);
    chk_log(0, 32'd20, 4'b0001, 1'b1, "R3 write first");
    chk_log(1, 32'd24, 4'b1110, 1'b1, "R3 write second");
    chk({mem[24], mem[23], mem[22], mem[21]} == 32'hA1B2_C3D4, "R5 word bytes",
        {mem[24], mem[23], mem[22], mem[21]}, 32'hA1B2_C3D4);
    chk(mem[20] == b20 && mem[25] == b25, "R5 neighbours kept",
        {16'b0, mem[20], mem[25]}, {16'b0, b20, b25});
    b32 = mem[32];
    run_acc(1'b1, 2'd1, 30, 32'hFFFF_5A6B, 1'b0, r);
    chk(log_n == 1, "R2 half write one cycle", log_n, 1);
    chk_log(0, 32'd28, 4'b0011, 1'b1, "R4 half write lanes");
    chk({mem[31], mem[30]} == 16'h5A6B, "R5 half bytes", {16'b0, mem[31], mem[30]}, 32'h5A6B);
    chk(mem[32] == b32, "R5 upper word kept", {24'b0, mem[32]}, {24'b0, b32});
    run_acc(1'b1, 2'd1, 31, 32'h0000_1234, 1'b0, r);
    chk(log_n == 2, "R3 half write split", log_n, 2);
    chk_log(0, 32'd28, 4'b0111, 1'b1, "R3 half write first");
    chk_log(1, 32'd32, 4'b1110, 1'b1, "R3 half write second");
    chk({mem[32], mem[31]} == 16'h1234, "R5 split half bytes", {16'b0, mem[32], mem[31]}, 32'h1234);
    b41 = mem[41];
    run_acc(1'b1, 2'd0, 40, 32'hCCCC_CC77, 1'b0, r);
    chk_log(0, 32'd40, 4'b1110, 1'b1, "R4 byte write lane");
    chk(mem[40] == 8'h77 && mem[41] == b41, "R5 byte write",
        {16'b0, mem[40], mem[41]}, {16'b0, 8'h77, b41});
    chk(excl_err == 0, "R11 never both", excl_err, 0);
  endtask

  task automatic t_waits;
    logic [31:0] r;
    wait_n = 3;
    run_acc(1'b0, 2'd1, 7, 32'h0, 1'b0, r);
    chk(log_n == 2, "R9 cycles with waits", log_n, 2);
    chk_log(1, 32'd8, 4'b1110, 1'b0, "R9 second after waits");
    chk(r == exp_read(7, 2), "R9 data with waits", r, exp_read(7, 2));
    run_acc(1'b1, 2'd2, 45, 32'h1122_3344, 1'b0, r);
    chk({mem[48], mem[47], mem[46], mem[45]} == 32'h1122_3344, "R9 write with waits",
        {mem[48], mem[47], mem[46], mem[45]}, 32'h1122_3344);
    chk(hold_err == 0, "R9 held while waiting", hold_err, 0);
    wait_n = 0;
  endtask

  task automatic t_narrow;
    logic [31:0] r;
    run_acc(1'b0, 2'd2, 8, 32'h0, 1'b1, r);
    chk(log_n == 2, "R8 aligned word cycles", log_n, 2);
    chk_log(0, 32'd8, 4'b1100, 1'b0, "R8 first half");
    chk_log(1, 32'd10, 4'b1100, 1'b0, "R8 second half");
    chk(r == exp_read(8, 4), "R8 word data", r, exp_read(8, 4));
    run_acc(1'b0, 2'd2, 9, 32'h0, 1'b1, r);
    chk(log_n == 3, "R8 odd word cycles", log_n, 3);
    chk_log(0, 32'd8, 4'b1101, 1'b0, "R8 odd first");
    chk_log(1, 32'd10, 4'b1100, 1'b0, "R8 odd middle");
    chk_log(2, 32'd12, 4'b1110, 1'b0, "R8 odd last");
    chk(r == exp_read(9, 4), "R8 odd word data", r, exp_read(9, 4));
    run_acc(1'b1, 2'd1, 3, 32'h0000_BEEF, 1'b1, r);
    chk(log_n == 2, "R8 half write cycles", log_n, 2);
    chk_log(0, 32'd2, 4'b1101, 1'b1, "R8 half write first");
    chk_log(1, 32'd4, 4'b1110, 1'b1, "R8 half write second");
    chk({mem[4], mem[3]} == 16'hBEEF, "R8 half write bytes", {16'b0, mem[4], mem[3]}, 32'hBEEF);
    run_acc(1'b0, 2'd0, 7, 32'h0, 1'b1, r);
    chk(log_n == 1, "R8 byte one cycle", log_n, 1);
    chk_log(0, 32'd6, 4'b1101, 1'b0, "R8 byte lane");
    chk(r == exp_read(7, 1), "R8 byte data", r, exp_read(7, 1));
  endtask

  bit finished = 1'b0;

  initial begin
    #600000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_size   = 2'd0;
    req_addr   = '0;
    req_wdata  = '0;
    bus_narrow = 1'b0;
    bus_ready  = 1'b0;
    bus_rdata  = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_wide_single;
    t_wide_split;
    t_writes;
    t_waits;
    t_narrow;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule